// File: doc/BRIEF.md
# Touch Measurement Sequence Controller

This block runs a complete touch-panel measurement pass on its own once software writes a single command word. The command picks a channel list, a burst length and a settling wait. For every channel in the list the controller selects the panel drive configuration, issues a burst of conversion requests to the converter (waiting the programmed interval before each one), tells the averager how long the burst is, and stores the averaged value in the next result slot. The converter, the averager, the analog switches and the register file that software reads are separate blocks.

While a pass runs, the active-low pen interrupt output is held low so the host sees the controller as busy. When the last result is stored, the output goes high to announce that data is ready. It stays high for a fixed holdoff so the host can see the edge, and then returns to reporting pen contact. A 4-bit status field reports idle, busy or data ready. Data-ready ends when the register interface reports that every stored slot has been read.

Top module: `tsc_seq_ctrl`

## Requirements
- R1: A command is taken when `cmd_valid` is high while status is idle and the mode is supported. The command layout is mode = `cmd_word[6:4]`, burst select = `cmd_word[3]`, interval code = `cmd_word[2:0]`. Status reads busy in the cycle after the command.
- R2: The mode sets the channel order. 000 gives X,Y,Z1,Z2. 001 gives X,Y. 010 gives X. 011 gives Y. 100 gives Z1,Z2. 110 gives the auxiliary input. While busy, `chan_sel` carries the current channel, coded auxiliary=3, X=4, Y=5, Z1=6, Z2=7.
- R3: Each channel receives exactly 6 single-cycle `conv_req` pulses when the burst select is 0, and 10 when it is 1. `avg_len` shows the burst length. `avg_start` pulses once per channel, before the first request of that channel.
- R4: Interval codes 0 to 7 give waits of 0, 5, 10, 20, 50, 100, 200 and 500 µs, counted in ticks of CLK_PER_US clocks. Within a burst, if `conv_done` is high in cycle k, the next `conv_req` is high in cycle k + wait·CLK_PER_US + 2.
- R5: Each `avg_valid` produces one `wr_en` cycle. `wr_data` equals `avg_result`. `wr_slot` counts 0, 1, 2, 3 in channel order.
- R6: `status` reads 0000 when idle, 0001 when busy and 0010 when data is ready. `conv_req` is only ever high while busy.
- R7: `pen_irq_n` is low and `osc_en` is high throughout busy. From the cycle that stores the last result, both are held high for HOLDOFF_US·CLK_PER_US + 1 cycles. After that, `osc_en` is low.
- R8: Outside busy and outside the holdoff, `pen_irq_n` equals the inverse of `touch_det` when `pd_hold` is 0, and is held low when `pd_hold` is 1.
- R9: Reserved modes 101 and 111 are ignored. Modes 000, 100 and 110 are also ignored when `panel_5w` is 1. In either case status stays 0000 and no conversion is requested.
- R10: A command that arrives while busy or while data is ready is ignored. It adds no requests and no writes, and it leaves the channel list unchanged.
- R11: `slots_cleared` while data is ready returns status to 0000 in the next cycle.
- R12: After reset, status is 0000 and `conv_req`, `wr_en`, `avg_start` and `osc_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word write strobe |
| cmd_word | input | 7 | Mode [6:4], burst select [3], interval code [2:0] |
| panel_5w | input | 1 | 1 = 5-wire panel, 0 = 4-wire panel |
| pd_hold | input | 1 | Drivers-held bit; 1 forces the pen interrupt low when not busy |
| touch_det | input | 1 | Raw touch-detect level, 1 = touched |
| conv_done | input | 1 | Converter finished the requested conversion |
| avg_valid | input | 1 | Averager result strobe |
| avg_result | input | DATA_W | Averaged burst value |
| slots_cleared | input | 1 | Register interface reports all slots read |
| conv_req | output | 1 | Single-cycle conversion request |
| chan_sel | output | 3 | Channel / switch configuration select |
| avg_start | output | 1 | Start of a new burst for the averager |
| avg_len | output | LEN_W | Burst length of the current pass |
| wr_en | output | 1 | Result slot write strobe |
| wr_slot | output | SLOT_W | Result slot index |
| wr_data | output | DATA_W | Result slot data |
| pen_irq_n | output | 1 | Active-low pen / data-ready interrupt |
| status | output | 4 | Sequence status field |
| osc_en | output | 1 | Conversion oscillator enable |

## Verification
The bench builds the block with CLK_PER_US = 4 and HOLDOFF_US = 20. This makes every interval code, including the 500 µs wait, and the full holdoff window cheap enough to check cycle-exactly. A converter responder and a counting averager model sit around the block. Each stored result therefore encodes its channel and the number of conversions it received, so the channel order, the burst length and the slot order are all checked from the written data. Reserved modes and modes that are not allowed on 5-wire panels are walked through the same table as the legal ones.

// File: rtl/tsc_seq_pkg.sv
// Shared constants, state type and decode functions for the touch
// measurement sequence controller.
package tsc_seq_pkg;

    // Channel / switch configuration codes shown on chan_sel.
    localparam logic [2:0] CH_AUX = 3'd3;
    localparam logic [2:0] CH_X   = 3'd4;
    localparam logic [2:0] CH_Y   = 3'd5;
    localparam logic [2:0] CH_Z1  = 3'd6;
    localparam logic [2:0] CH_Z2  = 3'd7;

    // Status field codes.
    localparam logic [3:0] STAT_IDLE  = 4'd0;
    localparam logic [3:0] STAT_BUSY  = 4'd1;
    localparam logic [3:0] STAT_READY = 4'd2;

    // Longest interval in microseconds and its width.
    localparam int IVL_MAX_US = 500;
    localparam int IVL_W      = $clog2(IVL_MAX_US + 1);

    typedef enum logic [2:0] {
        S_IDLE, S_WAIT, S_REQ, S_CONV, S_AVG, S_HOLD, S_READY
    } seq_state_e;

    // Interval code to microseconds.
    function automatic logic [IVL_W-1:0] ivl_us(input logic [2:0] code);
        case (code)
            3'd0:    ivl_us = IVL_W'(0);
            3'd1:    ivl_us = IVL_W'(5);
            3'd2:    ivl_us = IVL_W'(10);
            3'd3:    ivl_us = IVL_W'(20);
            3'd4:    ivl_us = IVL_W'(50);
            3'd5:    ivl_us = IVL_W'(100);
            3'd6:    ivl_us = IVL_W'(200);
            default: ivl_us = IVL_W'(IVL_MAX_US);
        endcase
    endfunction

    // Number of channels a mode scans (0 = reserved).
    function automatic logic [2:0] plan_len(input logic [2:0] mode);
        case (mode)
            3'b000:  plan_len = 3'd4;
            3'b001:  plan_len = 3'd2;
            3'b010:  plan_len = 3'd1;
            3'b011:  plan_len = 3'd1;
            3'b100:  plan_len = 3'd2;
            3'b110:  plan_len = 3'd1;
            default: plan_len = 3'd0;
        endcase
    endfunction

    // Modes that need the second plate or the auxiliary pin.
    function automatic logic plan_4w_only(input logic [2:0] mode);
        plan_4w_only = (mode == 3'b000) || (mode == 3'b100) || (mode == 3'b110);
    endfunction

    // Channel at position idx of a mode's scan list.
    function automatic logic [2:0] plan_chan(input logic [2:0] mode, input logic [1:0] idx);
        case (mode)
            3'b000: begin
                case (idx)
                    2'd0:    plan_chan = CH_X;
                    2'd1:    plan_chan = CH_Y;
                    2'd2:    plan_chan = CH_Z1;
                    default: plan_chan = CH_Z2;
                endcase
            end
            3'b001:  plan_chan = (idx == 2'd0) ? CH_X : CH_Y;
            3'b011:  plan_chan = CH_Y;
            3'b100:  plan_chan = (idx == 2'd0) ? CH_Z1 : CH_Z2;
            3'b110:  plan_chan = CH_AUX;
            default: plan_chan = CH_X;
        endcase
    endfunction

endpackage

// File: rtl/tsc_mode_decode.sv
// Mode decoder: turns a mode code and panel type into a support flag,
// a channel count and the channel at a given list position.
// Assumes: purely combinational; caller holds mode stable while busy.
module tsc_mode_decode
    import tsc_seq_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       panel_5w,
    input  logic [1:0] idx,
    output logic       ok,
    output logic [2:0] n_ch,
    output logic [2:0] chan
);

    // Decode support, length and current channel.
    always_comb begin
        n_ch = plan_len(mode);
        ok   = (n_ch != 3'd0) && !(panel_5w && plan_4w_only(mode));
        chan = plan_chan(mode, idx);
    end

endmodule

// File: rtl/tsc_us_timer.sv
// Microsecond down-counter with its own prescaler. A load restarts the
// prescaler, so a wait of N microseconds ends exactly N*CLK_PER_US clocks
// after the load. expired is high while the count is zero.
// Assumes: CLK_PER_US >= 1.
module tsc_us_timer #(
    parameter int CLK_PER_US = 50,
    parameter int CNT_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    localparam int              PRE_W    = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] rem_q;

    // Prescale the clock to microseconds and count the wait down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            rem_q <= '0;
        end else if (load) begin
            pre_q <= '0;
            rem_q <= load_val;
        end else if (rem_q != '0) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                rem_q <= rem_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign expired = (rem_q == '0);

    // Without a load the count only holds or steps down by one (R4).
    assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && rem_q != '0) |=> (rem_q == $past(rem_q) || rem_q == $past(rem_q) - 1'b1));

    // An idle timer stays expired until reloaded (R4).
    assert_timer_rest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);

endmodule

// File: rtl/tsc_seq_ctrl.sv
// Touch measurement sequence controller (top).
// Takes a command word and walks the chosen channel list. For each
// channel it waits the programmed interval before every conversion,
// requests a burst of conversions, waits for the averager and writes
// the result to the next slot. It drives the pen interrupt as a
// busy / data-ready flag with a holdoff after completion.
// Assumes: conv_done answers each conv_req once; avg_valid follows the
// last conversion of a burst; synchronous active-low reset.
module tsc_seq_ctrl
    import tsc_seq_pkg::*;
#(
    parameter int CLK_PER_US  = 50,
    parameter int HOLDOFF_US  = 20,
    parameter int DATA_W      = 12,
    parameter int SHORT_BURST = 6,
    parameter int LONG_BURST  = 10,
    parameter int SLOT_N      = 4,
    localparam int LEN_W      = $clog2(LONG_BURST + 1),
    localparam int SLOT_W     = $clog2(SLOT_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [6:0]        cmd_word,
    input  logic              panel_5w,
    input  logic              pd_hold,
    input  logic              touch_det,
    input  logic              conv_done,
    input  logic              avg_valid,
    input  logic [DATA_W-1:0] avg_result,
    input  logic              slots_cleared,
    output logic              conv_req,
    output logic [2:0]        chan_sel,
    output logic              avg_start,
    output logic [LEN_W-1:0]  avg_len,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [DATA_W-1:0] wr_data,
    output logic              pen_irq_n,
    output logic [3:0]        status,
    output logic              osc_en
);

    localparam int TMR_MAX = (HOLDOFF_US > IVL_MAX_US) ? HOLDOFF_US : IVL_MAX_US;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    seq_state_e       state;
    logic [2:0]       mode_q;
    logic             long_q;
    logic [2:0]       ivl_q;
    logic [1:0]       idx_q;
    logic [2:0]       nch_q;
    logic [LEN_W-1:0] cnt_q;
    logic             start_q;

    logic [2:0]       mode_src;
    logic             dec_ok;
    logic [2:0]       dec_nch;
    logic [2:0]       dec_chan;
    logic             accept;
    logic             busy;
    logic [LEN_W-1:0] burst_len;
    logic             last_conv;
    logic             last_ch;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;

    // Decode the incoming mode when idle, the held mode otherwise.
    assign mode_src = (state == S_IDLE) ? cmd_word[6:4] : mode_q;

    tsc_mode_decode u_decode (
        .mode     (mode_src),
        .panel_5w (panel_5w),
        .idx      (idx_q),
        .ok       (dec_ok),
        .n_ch     (dec_nch),
        .chan     (dec_chan)
    );

    tsc_us_timer #(
        .CLK_PER_US (CLK_PER_US),
        .CNT_W      (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    // Burst bookkeeping terms.
    always_comb begin
        accept    = (state == S_IDLE) && cmd_valid && dec_ok;
        busy      = (state == S_WAIT) || (state == S_REQ) ||
                    (state == S_CONV) || (state == S_AVG);
        burst_len = long_q ? LEN_W'(LONG_BURST) : LEN_W'(SHORT_BURST);
        last_conv = ((cnt_q + LEN_W'(1)) == burst_len);
        last_ch   = ((3'(idx_q) + 3'd1) == nch_q);
    end

    // Choose when the timer restarts and with which wait.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(ivl_us(ivl_q));
        case (state)
            S_IDLE: if (accept) begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(ivl_us(cmd_word[2:0]));
            end
            S_CONV: if (conv_done && !last_conv) tmr_load = 1'b1;
            S_AVG: if (avg_valid) begin
                tmr_load = 1'b1;
                if (last_ch) tmr_val = TMR_W'(HOLDOFF_US);
            end
            default: ;
        endcase
    end

    // Sequence state machine and held command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            mode_q  <= 3'b000;
            long_q  <= 1'b0;
            ivl_q   <= 3'd0;
            idx_q   <= 2'd0;
            nch_q   <= 3'd0;
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state)
                S_IDLE: if (accept) begin
                    mode_q  <= cmd_word[6:4];
                    long_q  <= cmd_word[3];
                    ivl_q   <= cmd_word[2:0];
                    nch_q   <= dec_nch;
                    idx_q   <= 2'd0;
                    cnt_q   <= '0;
                    start_q <= 1'b1;
                    state   <= S_WAIT;
                end
                S_WAIT: if (tmr_expired) state <= S_REQ;
                S_REQ:  state <= S_CONV;
                S_CONV: if (conv_done) begin
                    cnt_q <= cnt_q + LEN_W'(1);
                    state <= last_conv ? S_AVG : S_WAIT;
                end
                S_AVG: if (avg_valid) begin
                    if (last_ch) begin
                        state <= S_HOLD;
                    end else begin
                        idx_q   <= idx_q + 2'd1;
                        cnt_q   <= '0;
                        start_q <= 1'b1;
                        state   <= S_WAIT;
                    end
                end
                S_HOLD: begin
                    if (slots_cleared)    state <= S_IDLE;
                    else if (tmr_expired) state <= S_READY;
                end
                S_READY: if (slots_cleared) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Output decode: handshakes, slot writes, status and interrupt.
    always_comb begin
        conv_req  = (state == S_REQ);
        avg_start = start_q;
        avg_len   = burst_len;
        chan_sel  = busy ? dec_chan : CH_X;
        wr_en     = (state == S_AVG) && avg_valid;
        wr_slot   = SLOT_W'(idx_q);
        wr_data   = avg_result;
        osc_en    = busy || (state == S_HOLD);
        if (busy)
            status = STAT_BUSY;
        else if (state == S_HOLD || state == S_READY)
            status = STAT_READY;
        else
            status = STAT_IDLE;
        if (busy)
            pen_irq_n = 1'b0;
        else if (state == S_HOLD)
            pen_irq_n = 1'b1;
        else
            pen_irq_n = pd_hold ? 1'b0 : !touch_det;
    end

    // Busy always shows as a low interrupt and a running oscillator (R7).
    assert_busy_irq_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STAT_BUSY) |-> (!pen_irq_n && osc_en));

    // Requests are single-cycle pulses (R3).
    assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // Requests only while busy (R6).
    assert_req_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (status == STAT_BUSY));

    // Writes stay within the channel list (R5).
    assert_slot_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (3'(wr_slot) < nch_q));

    // A command during a pass leaves the held mode alone (R10).
    assert_ignore_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status != STAT_IDLE && cmd_valid) |=> $stable(mode_q));

    // Clearing the slots ends data-ready (R11).
    assert_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status == STAT_READY && slots_cleared) |=> (status == STAT_IDLE));

    // Status never shows more than one flag (R6).
    assert_status_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status));

endmodule

// File: tb/tsc_seq_ctrl_bench.sv
module tsc_seq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 4;
    localparam int HOLD       = 20;
    localparam int DW         = 12;

    typedef struct packed {
        logic [2:0]  mode;
        logic        cnt;
        logic [2:0]  ivl;
        logic        p5;
        logic [2:0]  n;
        logic [11:0] chans;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{3'b000, 1'b0, 3'd0, 1'b0, 3'd4, {3'd4, 3'd5, 3'd6, 3'd7}},
        '{3'b001, 1'b1, 3'd1, 1'b0, 3'd2, {3'd4, 3'd5, 6'd0}},
        '{3'b010, 1'b0, 3'd2, 1'b1, 3'd1, {3'd4, 9'd0}},
        '{3'b011, 1'b1, 3'd3, 1'b1, 3'd1, {3'd5, 9'd0}},
        '{3'b100, 1'b0, 3'd0, 1'b0, 3'd2, {3'd6, 3'd7, 6'd0}},
        '{3'b110, 1'b0, 3'd1, 1'b0, 3'd1, {3'd3, 9'd0}},
        '{3'b101, 1'b0, 3'd0, 1'b0, 3'd0, 12'd0},
        '{3'b111, 1'b0, 3'd0, 1'b0, 3'd0, 12'd0},
        '{3'b000, 1'b0, 3'd0, 1'b1, 3'd0, 12'd0},
        '{3'b100, 1'b0, 3'd0, 1'b1, 3'd0, 12'd0},
        '{3'b110, 1'b0, 3'd0, 1'b1, 3'd0, 12'd0},
        '{3'b001, 1'b0, 3'd4, 1'b1, 3'd2, {3'd4, 3'd5, 6'd0}}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [6:0]    cmd_word = '0;
    logic          panel_5w = 1'b0;
    logic          pd_hold = 1'b0;
    logic          touch_det = 1'b0;
    logic          conv_done = 1'b0;
    logic          avg_valid = 1'b0;
    logic [DW-1:0] avg_result = '0;
    logic          slots_cleared = 1'b0;
    logic          conv_req, avg_start, wr_en, pen_irq_n, osc_en;
    logic [2:0]    chan_sel;
    logic [3:0]    avg_len;
    logic [1:0]    wr_slot;
    logic [DW-1:0] wr_data;
    logic [3:0]    status;

    tsc_seq_ctrl #(.CLK_PER_US(CPU), .HOLDOFF_US(HOLD), .DATA_W(DW)) u_tsc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .panel_5w(panel_5w), .pd_hold(pd_hold), .touch_det(touch_det),
        .conv_done(conv_done), .avg_valid(avg_valid), .avg_result(avg_result),
        .slots_cleared(slots_cleared), .conv_req(conv_req), .chan_sel(chan_sel),
        .avg_start(avg_start), .avg_len(avg_len), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_data(wr_data), .pen_irq_n(pen_irq_n), .status(status), .osc_en(osc_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int done_cd = 0, acc = 0, av_cd = 0;
    int rec_n = 0, req_n = 0, start_n = 0, gap_err = 0, busy_err = 0;
    int last_done = 0, exp_gap = 2;
    bit pend = 0;
    logic [1:0]    rec_slot [64];
    logic [DW-1:0] rec_data [64];

    always @(posedge clk) cyc <= cyc + 1;

    // Converter model: answers each request three cycles later.
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (!rst_n) done_cd <= 0;
        else if (conv_req) done_cd <= 3;
        else if (done_cd > 0) begin
            done_cd <= done_cd - 1;
            if (done_cd == 1) conv_done <= 1'b1;
        end
    end

    // Averager model: result encodes channel and conversion count.
    always @(posedge clk) begin
        avg_valid <= 1'b0;
        if (!rst_n) begin
            acc <= 0; av_cd <= 0;
        end else begin
            if (avg_start) acc <= 0;
            else if (conv_done) begin
                acc <= acc + 1;
                if (acc + 1 == int'(avg_len)) av_cd <= 2;
            end
            if (av_cd > 0) begin
                av_cd <= av_cd - 1;
                if (av_cd == 1) begin
                    avg_valid  <= 1'b1;
                    avg_result <= {chan_sel, 4'(acc), 5'b10101};
                end
            end
        end
    end

    // Monitor: records writes, counts requests, checks wait gaps.
    always @(posedge clk) begin
        if (rst_n) begin
            if (wr_en && rec_n < 64) begin
                rec_slot[rec_n] <= wr_slot;
                rec_data[rec_n] <= wr_data;
                rec_n <= rec_n + 1;
            end
            if (conv_req) req_n <= req_n + 1;
            if (avg_start) start_n <= start_n + 1;
            if (conv_done) begin last_done <= cyc; pend <= 1; end
            if (avg_valid) pend <= 0;
            if (conv_req && pend && (cyc - last_done != exp_gap)) gap_err <= gap_err + 1;
            if (status == 4'd1 && (pen_irq_n || !osc_en)) busy_err <= busy_err + 1;
        end
    end

    function automatic int us_of(input logic [2:0] c);
        case (c)
            3'd0: return 0;   3'd1: return 5;   3'd2: return 10;  3'd3: return 20;
            3'd4: return 50;  3'd5: return 100; 3'd6: return 200; default: return 500;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [6:0] w);
        @(negedge clk); cmd_word = w; cmd_valid = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic clear_slots();
        @(negedge clk); slots_cleared = 1'b1;
        @(negedge clk); slots_cleared = 1'b0;
        chk(status == 4'd0, "R11 status after slots_cleared", int'(status), 0);
    endtask

    task automatic run_vec(input vec_t v);
        int b_rec, b_req, b_st, b_gap, b_busy, len, hi;
        b_rec = rec_n; b_req = req_n; b_st = start_n; b_gap = gap_err; b_busy = busy_err;
        len = v.cnt ? 10 : 6;
        exp_gap = us_of(v.ivl) * CPU + 2;
        panel_5w = v.p5;
        touch_det = 1'b1;
        send_cmd({v.mode, v.cnt, v.ivl});
        if (v.n == 3'd0) begin
            chk(status == 4'd0, "R9 ignored mode status", int'(status), 0);
            repeat (30) @(negedge clk);
            chk(req_n == b_req, "R9 ignored mode requests", req_n - b_req, 0);
            chk(status == 4'd0, "R9 ignored mode stays idle", int'(status), 0);
        end else begin
            chk(status == 4'd1, "R1 busy after command", int'(status), 1);
            while (status != 4'd2) @(negedge clk);
            hi = 0;
            while (status == 4'd2 && pen_irq_n && osc_en && hi < 1000) begin
                hi++; @(negedge clk);
            end
            chk(hi == HOLD * CPU + 1, "R7 holdoff length", hi, HOLD * CPU + 1);
            chk(!osc_en && !pen_irq_n, "R7 after holdoff osc/irq", int'({osc_en, pen_irq_n}), 0);
            chk(status == 4'd2, "R6 data ready status", int'(status), 2);
            chk(rec_n - b_rec == int'(v.n), "R5 write count", rec_n - b_rec, int'(v.n));
            for (int i = 0; i < int'(v.n); i++) begin
                logic [2:0] ch;
                ch = v.chans[11 - 3*i -: 3];
                chk(rec_slot[b_rec + i] == 2'(i), "R5 slot order", int'(rec_slot[b_rec + i]), i);
                chk(rec_data[b_rec + i] == {ch, 4'(len), 5'b10101}, "R2 channel order / R3 burst data",
                    int'(rec_data[b_rec + i]), int'({ch, 4'(len), 5'b10101}));
            end
            chk(req_n - b_req == len * int'(v.n), "R3 request count", req_n - b_req, len * int'(v.n));
            chk(start_n - b_st == int'(v.n), "R3 burst starts", start_n - b_st, int'(v.n));
            chk(gap_err == b_gap, "R4 interval gap", gap_err - b_gap, 0);
            chk(busy_err == b_busy, "R7 busy irq/osc", busy_err - b_busy, 0);
            clear_slots();
        end
    endtask

    initial begin
        repeat (20000 * 7 + 10000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int b_req, b_rec;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(status == 4'd0, "R12 reset status", int'(status), 0);
        chk(!conv_req && !wr_en && !avg_start && !osc_en, "R12 reset outputs",
            int'({conv_req, wr_en, avg_start, osc_en}), 0);
        // R8 idle interrupt behaviour
        chk(pen_irq_n == 1'b1, "R8 idle untouched", int'(pen_irq_n), 1);
        touch_det = 1'b1; #1;
        chk(pen_irq_n == 1'b0, "R8 idle touched", int'(pen_irq_n), 0);
        touch_det = 1'b0; pd_hold = 1'b1; #1;
        chk(pen_irq_n == 1'b0, "R8 pd_hold forces low", int'(pen_irq_n), 0);
        pd_hold = 1'b0;

        for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

        // R4 longest interval
        run_vec('{3'b010, 1'b0, 3'd7, 1'b0, 3'd1, {3'd4, 9'd0}});

        // R10 commands while busy and while data ready are ignored
        b_req = req_n; b_rec = rec_n;
        exp_gap = us_of(3'd2) * CPU + 2;
        panel_5w = 1'b0; touch_det = 1'b1;
        send_cmd({3'b010, 1'b0, 3'd2});
        repeat (20) @(negedge clk);
        send_cmd({3'b000, 1'b1, 3'd0});
        chk(chan_sel == 3'd4, "R10 channel kept while busy", int'(chan_sel), 4);
        while (status != 4'd2) @(negedge clk);
        send_cmd({3'b010, 1'b0, 3'd0});
        chk(status == 4'd2, "R10 command in data ready", int'(status), 2);
        repeat (30) @(negedge clk);
        chk(req_n - b_req == 6, "R10 no extra requests", req_n - b_req, 6);
        chk(rec_n - b_rec == 1 && rec_data[b_rec] == {3'd4, 4'd6, 5'b10101}, "R10 single write",
            rec_n - b_rec, 1);
        clear_slots();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule